// File: doc/BRIEF.md
# Nested Hardware Loop Controller

This block lets a small processor core repeat a range of instructions with no branch overhead. A loop-start command gives the address of the last instruction word of the body and a repeat count. On each cycle the unit compares the fetched program counter with the stored end address. If the count still allows another pass, it requests a branch back to the top of the body in the same cycle and lowers the count by one. When the count runs out, the loop ends and control falls through.

One level of nesting is supported. A shadow end address and a shadow count hold the outer loop's state while an inner loop runs, and a nesting flag records that the outer loop was active. When the inner loop ends, the outer state is restored from the shadows. A second start variant uses the count already held in the count register. All four registers can be read and written through a 32-bit access port, so software can move them or save and restore them. Addresses are 24 bits and counts are 16 bits. Both are zero-extended on reads and truncated on writes.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset all four registers read zero, both flags are clear and `branch_back` is low.
- R2: A start with `start_use_lc`=0 and a nonzero `start_cnt` updates state on the next edge: the shadow address takes the old end address, the end address takes `start_end_addr`, the shadow count takes the old count, the count takes `start_cnt`, the nesting flag takes the old loop flag, and the loop flag is set.
- R3: A start with `start_use_lc`=1 uses the present count as the repeat count. Count and shadow count are left unchanged, and the addresses and flags move as in R2. If the present count is zero, the start is skipped.
- R4: A start whose effective count is zero changes no register and no flag.
- R5: `branch_back` is high in the same cycle when `pc_vld` is high, `pc` equals the end address, the loop flag is set and the count is greater than one. The count then drops by one at the next edge.
- R6: When the match conditions of R5 hold but the count is one or less, the loop ends. `branch_back` stays low. At the next edge the end address takes the shadow address, the loop flag takes the nesting flag, and the nesting flag clears. The count takes the shadow count only if the nesting flag was set; otherwise it is kept.
- R7: `acc_rdata` shows the register chosen by `acc_sel` (0 end address, 1 shadow address, 2 count, 3 shadow count), zero-extended to 32 bits.
- R8: A write with `acc_we` stores bits 23:0 of `acc_wdata` into an address register, or bits 15:0 into a count register.
- R9: Priority order is a taken start, then an end-address match, then a register write. In a cycle with a taken start, `branch_back` is low and no decrement or exit happens. A write in a cycle with a taken start or a match is dropped.
- R10: The nesting flag is never set while the loop flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_vld | input | 1 | Loop-start command |
| start_use_lc | input | 1 | 1: use the present count register as repeat count |
| start_end_addr | input | 24 | Address of the last word of the loop body |
| start_cnt | input | 16 | Repeat count for the explicit-count start |
| pc_vld | input | 1 | `pc` holds a fetched instruction address |
| pc | input | 24 | Current program counter |
| acc_we | input | 1 | Register write strobe |
| acc_sel | input | 2 | Register select: 0 end, 1 shadow end, 2 count, 3 shadow count |
| acc_wdata | input | 32 | Register write data |
| acc_rdata | output | 32 | Selected register, zero-extended |
| branch_back | output | 1 | Branch to the top of the loop body this cycle |
| loop_flag | output | 1 | A loop is active |
| nest_flag | output | 1 | An outer loop is parked in the shadows |

## Verification
The key overlap is a loop-start command that arrives in the same cycle the program counter hits the active end address. A second overlap is a register write arriving together with an end-address match. Both are provoked on purpose: a new start is issued while the fetched address sits on the current loop end, and a shadow-address write is issued while a branch-back fires. A reference model in the bench applies the start-over-match-over-write order and predicts the branch request, the flags and every register read. Any mismatch, such as a stray decrement, a branch that should have been held off, or a write that landed, shows up in the cycle it occurs or on the read-back that follows.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  localparam int unsigned HL_ADDR_W = 24;
  localparam int unsigned HL_CNT_W  = 16;
  localparam int unsigned HL_BUS_W  = 32;
  localparam int unsigned HL_NREG   = 4;
  localparam int unsigned HL_SEL_W  = $clog2(HL_NREG);

  typedef logic [HL_ADDR_W-1:0] hl_addr_t;
  typedef logic [HL_CNT_W-1:0]  hl_cnt_t;
  typedef logic [HL_BUS_W-1:0]  hl_bus_t;

  typedef enum logic [HL_SEL_W-1:0] {
    SEL_END      = 2'd0,
    SEL_END_SAVE = 2'd1,
    SEL_CNT      = 2'd2,
    SEL_CNT_SAVE = 2'd3
  } hl_sel_e;

  function automatic hl_bus_t widen_addr(hl_addr_t a);
    return {{(HL_BUS_W-HL_ADDR_W){1'b0}}, a};
  endfunction

  function automatic hl_bus_t widen_cnt(hl_cnt_t c);
    return {{(HL_BUS_W-HL_CNT_W){1'b0}}, c};
  endfunction

  function automatic hl_addr_t narrow_addr(hl_bus_t w);
    return w[HL_ADDR_W-1:0];
  endfunction

  function automatic hl_cnt_t narrow_cnt(hl_bus_t w);
    return w[HL_CNT_W-1:0];
  endfunction

  // another pass remains when more than one iteration is left
  function automatic logic cnt_repeats(hl_cnt_t c);
    return c > hl_cnt_t'(1);
  endfunction

  function automatic hl_cnt_t cnt_step(hl_cnt_t c);
    return c - hl_cnt_t'(1);
  endfunction
endpackage

// File: rtl/hwloop_end_detect.sv
module hwloop_end_detect
  import hwloop_pkg::*;
(
  input  logic     pc_vld,
  input  hl_addr_t pc,
  input  hl_addr_t la,
  input  hl_cnt_t  lc,
  input  logic     lf,
  input  logic     start_take,
  output logic     at_end,
  output logic     ev_branch,
  output logic     ev_exit
);
  always_comb begin
    at_end    = pc_vld && lf && (pc == la) && !start_take;
    ev_branch = at_end && cnt_repeats(lc);
    ev_exit   = at_end && !cnt_repeats(lc);
  end
endmodule

// File: rtl/hwloop_addr_bank.sv
module hwloop_addr_bank
  import hwloop_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ev_start,
  input  hl_addr_t start_addr,
  input  logic     ev_exit,
  input  logic     wr_end,
  input  logic     wr_save,
  input  hl_addr_t wdata,
  output hl_addr_t la_q,
  output hl_addr_t la2_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      la_q  <= '0;
      la2_q <= '0;
    end else if (ev_start) begin
      la2_q <= la_q;
      la_q  <= start_addr;
    end else if (ev_exit) begin
      la_q <= la2_q;
    end else begin
      if (wr_end)  la_q  <= wdata;
      if (wr_save) la2_q <= wdata;
    end
  end
endmodule

// File: rtl/hwloop_cnt_bank.sv
module hwloop_cnt_bank
  import hwloop_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ev_start,
  input  logic    start_explicit,
  input  hl_cnt_t start_cnt,
  input  logic    ev_branch,
  input  logic    ev_exit,
  input  logic    nest_q,
  input  logic    wr_cnt,
  input  logic    wr_save,
  input  hl_cnt_t wdata,
  output hl_cnt_t lc_q,
  output hl_cnt_t lc2_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q  <= '0;
      lc2_q <= '0;
    end else if (ev_start) begin
      if (start_explicit) begin
        lc2_q <= lc_q;
        lc_q  <= start_cnt;
      end
    end else if (ev_branch) begin
      lc_q <= cnt_step(lc_q);
    end else if (ev_exit) begin
      if (nest_q) lc_q <= lc2_q;
    end else begin
      if (wr_cnt)  lc_q  <= wdata;
      if (wr_save) lc2_q <= wdata;
    end
  end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_vld,
  input  logic                start_use_lc,
  input  logic [HL_ADDR_W-1:0] start_end_addr,
  input  logic [HL_CNT_W-1:0]  start_cnt,
  input  logic                pc_vld,
  input  logic [HL_ADDR_W-1:0] pc,
  input  logic                acc_we,
  input  logic [HL_SEL_W-1:0]  acc_sel,
  input  logic [HL_BUS_W-1:0]  acc_wdata,
  output logic [HL_BUS_W-1:0]  acc_rdata,
  output logic                branch_back,
  output logic                loop_flag,
  output logic                nest_flag
);
  hl_addr_t la_q, la2_q;
  hl_cnt_t  lc_q, lc2_q;
  hl_cnt_t  cnt_eff;
  logic     ev_start, at_end, ev_branch, ev_exit, wr_ok;
  logic [HL_NREG-1:0] wr_vec;

  // effective count and start acceptance
  always_comb begin
    cnt_eff  = start_use_lc ? lc_q : start_cnt;
    ev_start = start_vld && (cnt_eff != '0);
  end

  hwloop_end_detect u_det (
    .pc_vld    (pc_vld),
    .pc        (pc),
    .la        (la_q),
    .lc        (lc_q),
    .lf        (loop_flag),
    .start_take(ev_start),
    .at_end    (at_end),
    .ev_branch (ev_branch),
    .ev_exit   (ev_exit)
  );

  assign wr_ok = acc_we && !ev_start && !at_end;

  for (genvar i = 0; i < HL_NREG; i++) begin : g_wdec
    assign wr_vec[i] = wr_ok && (acc_sel == HL_SEL_W'(i));
  end

  hwloop_addr_bank u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_start  (ev_start),
    .start_addr(start_end_addr),
    .ev_exit   (ev_exit),
    .wr_end    (wr_vec[SEL_END]),
    .wr_save   (wr_vec[SEL_END_SAVE]),
    .wdata     (narrow_addr(acc_wdata)),
    .la_q      (la_q),
    .la2_q     (la2_q)
  );

  hwloop_cnt_bank u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_start      (ev_start),
    .start_explicit(!start_use_lc),
    .start_cnt     (start_cnt),
    .ev_branch     (ev_branch),
    .ev_exit       (ev_exit),
    .nest_q        (nest_flag),
    .wr_cnt        (wr_vec[SEL_CNT]),
    .wr_save       (wr_vec[SEL_CNT_SAVE]),
    .wdata         (narrow_cnt(acc_wdata)),
    .lc_q          (lc_q),
    .lc2_q         (lc2_q)
  );

  // status flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_flag <= 1'b0;
      nest_flag <= 1'b0;
    end else if (ev_start) begin
      nest_flag <= loop_flag;
      loop_flag <= 1'b1;
    end else if (ev_exit) begin
      loop_flag <= nest_flag;
      nest_flag <= 1'b0;
    end
  end

  always_comb begin
    unique case (hl_sel_e'(acc_sel))
      SEL_END:      acc_rdata = widen_addr(la_q);
      SEL_END_SAVE: acc_rdata = widen_addr(la2_q);
      SEL_CNT:      acc_rdata = widen_cnt(lc_q);
      default:      acc_rdata = widen_cnt(lc2_q);
    endcase
  end

  assign branch_back = ev_branch;
endmodule

// File: rtl/hwloop_chk.sv
module hwloop_chk
  import hwloop_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     start_vld,
  input hl_addr_t start_end_addr,
  input logic     acc_we,
  input hl_bus_t  acc_rdata,
  input logic     branch_back,
  input logic     loop_flag,
  input logic     nest_flag,
  input logic     ev_start,
  input logic     ev_branch,
  input logic     ev_exit,
  input hl_addr_t la_q,
  input hl_addr_t la2_q,
  input hl_cnt_t  lc_q,
  input hl_cnt_t  lc2_q
);
  AST_START_SHADOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (la2_q == $past(la_q)) && (la_q == $past(start_end_addr)) && loop_flag); // R2
  AST_SKIP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_vld && !ev_start && !ev_branch && !ev_exit && !acc_we)
      |=> $stable(la_q) && $stable(la2_q) && $stable(lc_q) && $stable(lc2_q) && $stable(loop_flag)); // R4
  AST_BRANCH_NEEDS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    branch_back |-> loop_flag); // R5
  AST_BRANCH_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_branch |=> lc_q == hl_cnt_t'($past(lc_q) - hl_cnt_t'(1))); // R5
  AST_EXIT_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exit |=> (la_q == $past(la2_q)) && !nest_flag && (loop_flag == $past(nest_flag))); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rdata[HL_BUS_W-1:HL_ADDR_W] == '0); // R7
  AST_START_BLOCKS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> !branch_back && !ev_exit); // R9
  AST_NEST_NEEDS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    nest_flag |-> loop_flag); // R10
endmodule

bind hwloop_ctrl hwloop_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_vld     (start_vld),
  .start_end_addr(start_end_addr),
  .acc_we        (acc_we),
  .acc_rdata     (acc_rdata),
  .branch_back   (branch_back),
  .loop_flag     (loop_flag),
  .nest_flag     (nest_flag),
  .ev_start      (ev_start),
  .ev_branch     (ev_branch),
  .ev_exit       (ev_exit),
  .la_q          (la_q),
  .la2_q         (la2_q),
  .lc_q          (lc_q),
  .lc2_q         (lc2_q)
);

// File: tb/sim_hwloop_ctrl.sv
`timescale 1ns/1ps
module sim_hwloop_ctrl;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_vld = 1'b0, start_use_lc = 1'b0;
  logic [23:0] start_end_addr = '0;
  logic [15:0] start_cnt = '0;
  logic        pc_vld = 1'b0;
  logic [23:0] pc = '0;
  logic        acc_we = 1'b0;
  logic [1:0]  acc_sel = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        branch_back, loop_flag, nest_flag;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  hwloop_ctrl u0 (.*);

  typedef struct {
    string       tag;
    logic        br;
    logic [31:0] rd;
    logic        lf;
    logic        nl;
  } exp_t;
  exp_t sb[$];

  // bench reference state
  logic [23:0] m_la = '0, m_la2 = '0;
  logic [15:0] m_lc = '0, m_lc2 = '0;
  logic        m_lf = 0, m_nl = 0;

  function automatic logic [31:0] m_read(logic [1:0] s);
    case (s)
      2'd0: return {8'h00, m_la};
      2'd1: return {8'h00, m_la2};
      2'd2: return {16'h0000, m_lc};
      default: return {16'h0000, m_lc2};
    endcase
  endfunction

  // driver: one cycle of stimulus, predicted outputs, model update
  task automatic cyc(string tag, logic s, logic u, logic [23:0] e, logic [15:0] c,
                     logic pv, logic [23:0] p, logic we, logic [1:0] sel, logic [31:0] wd);
    exp_t it;
    logic [15:0] ceff;
    logic take, hit;
    @(negedge clk);
    start_vld = s; start_use_lc = u; start_end_addr = e; start_cnt = c;
    pc_vld = pv; pc = p; acc_we = we; acc_sel = sel; acc_wdata = wd;
    ceff = u ? m_lc : c;
    take = s && (ceff != 0);
    hit  = pv && m_lf && (p == m_la) && !take;
    it.tag = tag; it.br = hit && (m_lc > 1); it.rd = m_read(sel);
    it.lf = m_lf; it.nl = m_nl;
    sb.push_back(it);
    if (take) begin
      m_la2 = m_la; m_la = e;
      if (!u) begin m_lc2 = m_lc; m_lc = c; end
      m_nl = m_lf; m_lf = 1;
    end else if (hit) begin
      if (m_lc > 1) m_lc = m_lc - 1;
      else begin
        m_la = m_la2;
        if (m_nl) m_lc = m_lc2;
        m_lf = m_nl; m_nl = 0;
      end
    end else if (we) begin
      case (sel)
        2'd0: m_la  = wd[23:0];
        2'd1: m_la2 = wd[23:0];
        2'd2: m_lc  = wd[15:0];
        default: m_lc2 = wd[15:0];
      endcase
    end
  endtask

  task automatic rd(string tag, logic [1:0] sel);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, sel, 0);
  endtask
  task automatic wr(string tag, logic [1:0] sel, logic [31:0] wd);
    cyc(tag, 0, 0, 0, 0, 0, 0, 1, sel, wd);
  endtask
  task automatic go(string tag, logic [23:0] e, logic [15:0] c);
    cyc(tag, 1, 0, e, c, 0, 0, 0, 0, 0);
  endtask
  task automatic fetch(string tag, logic [23:0] p);
    cyc(tag, 0, 0, 0, 0, 1, p, 0, 2'd2, 0);
  endtask
  task automatic rd_all(string tag);
    for (int i = 0; i < 4; i++) rd(tag, 2'(i));
  endtask

  // monitor: compares queued predictions with the outputs of that cycle
  always @(negedge clk) begin
    #2;
    while (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      n_checks++;
      if (branch_back !== it.br || acc_rdata !== it.rd ||
          loop_flag !== it.lf || nest_flag !== it.nl) begin
        n_errors++;
        $display("FAIL %s: got br=%0b rd=%h lf=%0b nl=%0b, expected br=%0b rd=%h lf=%0b nl=%0b",
                 it.tag, branch_back, acc_rdata, loop_flag, nest_flag,
                 it.br, it.rd, it.lf, it.nl);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    rd_all("R1 reset state");
    // R8 truncation on writes, R7 zero-extended reads
    wr("R8 write end", 2'd0, 32'hFFAB_CDEF);
    wr("R8 write end save", 2'd1, 32'h0012_3456);
    wr("R8 write count", 2'd2, 32'hDEAD_0007);
    wr("R8 write count save", 2'd3, 32'h0000_0002);
    rd_all("R7 readback");
    // R2 explicit start, R5 branching, R6 exit
    go("R2 start", 24'h000100, 16'd3);
    rd_all("R2 state");
    fetch("R5 branch 1", 24'h000100);
    fetch("R5 off end", 24'h0000FF);
    fetch("R5 branch 2", 24'h000100);
    fetch("R6 exit single", 24'h000100);
    rd_all("R6 state");
    fetch("R6 no loop", 24'hABCDEF);
    // nesting
    go("R2 outer", 24'h000200, 16'd2);
    go("R2 inner", 24'h000180, 16'd2);
    rd_all("R2 nested state");
    fetch("R5 inner branch", 24'h000180);
    fetch("R6 inner exit", 24'h000180);
    rd_all("R6 outer restored");
    fetch("R5 outer branch", 24'h000200);
    fetch("R6 outer exit", 24'h000200);
    // zero count skip
    go("R4 zero count", 24'h000300, 16'd0);
    rd_all("R4 unchanged");
    // loaded-count start
    wr("R3 preload count", 2'd2, 32'h0000_0005);
    wr("R3 preload save", 2'd3, 32'h0000_0009);
    cyc("R3 loaded start", 1, 1, 24'h000400, 16'd77, 0, 0, 0, 2'd2, 0);
    rd_all("R3 state");
    fetch("R3 branch", 24'h000400);
    // same-cycle collisions
    cyc("R9 start vs end match", 1, 0, 24'h000500, 16'd2, 1, 24'h000400, 0, 2'd2, 0);
    rd_all("R9 after start");
    cyc("R9 write vs branch", 0, 0, 0, 0, 1, 24'h000500, 1, 2'd1, 32'h0000_0777);
    rd_all("R9 write dropped");
    fetch("R6 nested exit", 24'h000500);
    rd_all("R10 flags after exit");
    // loaded-count start with zero count
    wr("R3 zero preload", 2'd2, 32'h0000_0000);
    cyc("R3 loaded zero skip", 1, 1, 24'h000600, 16'd5, 0, 0, 0, 2'd0, 0);
    rd_all("R3 zero skip state");
    cyc("R9 write vs start", 1, 0, 24'h000700, 16'd4, 0, 0, 1, 2'd1, 32'h0000_0999);
    rd_all("R9 start wins");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule